// File: doc/BRIEF.md
# Load-Tracking Stride Prediction Table

This block remembers the load instructions that have missed in the second-level cache. For each one it learns whether successive addresses advance by a constant step. Entries sit in a small set-associative array whose sets are selected by bits of the load's program counter; the bits above them form the tag. Loads are written into the array through a miss-allocate port. A snoop port sees every executed load as a (PC, address) pair and refines the stride state of any entry the PC hits.

A run-ahead controller asks the table about a PC on the lookup port. The table answers combinationally with a hit flag, an eligibility flag and the predicted next address. Each entry carries two saturating 2-bit counters. One counts the misses of the load. The other counts how many of its recent addresses in a row matched the prediction. A load becomes eligible for prefetch only when both counters are at their ceiling.

Top module: `load_stride_tracker`

## Requirements
- R1: After reset no PC hits in the table: `lk_hit` and `lk_elig` are 0 for every queried PC.
- R2: The set is PC bits [PC_LSB+SET_BITS-1:PC_LSB] and the tag is every PC bit above them. PCs that share a set but differ in tag occupy separate ways, and activity in one set leaves other sets unchanged.
- R3: An entry is created only by `alc_vld` with a PC that misses. The new entry has last address = `alc_addr`, stride 0 and both counters 0. A snoop of an unknown PC creates nothing.
- R4: A missing allocation takes the lowest-numbered invalid way of its set. When the set is full it takes a way picked by a free-running LFSR. An allocation whose PC already hits never creates a second copy.
- R5: The predicted address is the entry's last address plus its 9-bit stride, sign-extended. A snoop hit always replaces the last address with the snooped address.
- R6: On a snoop hit whose address equals the prediction, the correct-prediction counter increments and saturates at 3. Otherwise it is cleared to 0 and the stride becomes the new delta (snooped address minus last address).
- R7: A delta outside -256..+255 counts as a misprediction and stores stride 0. The deltas +255 and -256 are stored as they are.
- R8: The miss counter starts at 0 on allocation. Each further `alc_vld` that hits the entry increments it, saturating at 3. Such an allocation leaves the address and stride state untouched.
- R9: `lk_elig` is 1 exactly when the looked-up entry hits with the miss counter at 3 and the correct-prediction counter at 3.
- R10: The lookup outputs reflect the table state before any write made in the same cycle.
- R11: If an allocation and a snoop write the same entry in one cycle, only the allocation's update takes effect.
- R12: With WAYS = 1 the table is direct-mapped: allocating a second tag into a set displaces the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alc_vld | input | 1 | A load missed in the second-level cache |
| alc_pc | input | 32 | PC of the missing load |
| alc_addr | input | 32 | Data address of the missing load |
| snp_vld | input | 1 | A load was executed |
| snp_pc | input | 32 | PC of the executed load |
| snp_addr | input | 32 | Data address of the executed load |
| lk_pc | input | 32 | PC queried by the run-ahead controller |
| lk_hit | output | 1 | Queried PC is present |
| lk_elig | output | 1 | Queried load meets both confidence thresholds |
| lk_pred | output | 32 | Predicted next address of the queried load |

## Verification
The assertions check several properties on every cycle:
- no PC ever matches more than one way on any port, and an allocation writes exactly one way;
- the LFSR never locks up at zero;
- a correct prediction always implies a delta that fits the stride field;
- the lookup outputs stay steady while neither write port touches the array.

Only the bench's scenarios show the learning sequence itself: how eligibility builds up through miss and prediction counting, the stride boundaries at +255, +256 and -256, the order of same-cycle writes and lookups, and the difference between the direct-mapped and two-way variants.

// File: rtl/lst_pkg.sv
package lst_pkg;
  localparam int unsigned PC_W     = 32;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned STRIDE_W = 9;
  localparam int unsigned CNT_W    = 2;

  typedef logic [ADDR_W-1:0]   addr_t;
  typedef logic [STRIDE_W-1:0] stride_t;
  typedef logic [CNT_W-1:0]    cnt_t;

  typedef struct packed {
    addr_t   last;
    stride_t stride;
    cnt_t    misses;
    cnt_t    streak;
  } meta_t;

  localparam cnt_t CNT_TOP = {CNT_W{1'b1}};

  function automatic addr_t sext_stride(stride_t s);
    return {{(ADDR_W-STRIDE_W){s[STRIDE_W-1]}}, s};
  endfunction

  function automatic addr_t next_guess(meta_t m);
    return m.last + sext_stride(m.stride);
  endfunction

  // delta fits when all bits from the stride sign bit upward agree
  function automatic logic stride_fits(addr_t d);
    logic [ADDR_W-STRIDE_W:0] hi;
    hi = d[ADDR_W-1:STRIDE_W-1];
    return (&hi) | ~(|hi);
  endfunction

  function automatic cnt_t bump(cnt_t c);
    return (c == CNT_TOP) ? c : c + cnt_t'(1);
  endfunction
endpackage

// File: rtl/lst_lfsr.sv
module lst_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = W'(8'hB8)
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= {{(W-1){1'b0}}, 1'b1};
    else        state <= {state[W-2:0], ^(state & TAPS)};
  end

  // R4
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n) state != '0);
endmodule

// File: rtl/lst_way.sv
module lst_way import lst_pkg::*; #(
  parameter int unsigned SET_BITS = 4,
  parameter int unsigned TAG_W    = 26,
  parameter int unsigned NRD      = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NRD-1:0][SET_BITS-1:0]   rd_idx,
  input  logic [NRD-1:0][TAG_W-1:0]      rd_tag,
  output logic [NRD-1:0]                 rd_hit,
  output logic [NRD-1:0]                 rd_valid,
  output meta_t [NRD-1:0]                rd_meta,
  input  logic                           upd_we,
  input  logic [SET_BITS-1:0]            upd_idx,
  input  meta_t                          upd_meta,
  input  logic                           alc_we,
  input  logic [SET_BITS-1:0]            alc_idx,
  input  logic [TAG_W-1:0]               alc_tag,
  input  meta_t                          alc_meta
);
  localparam int unsigned SETS = 1 << SET_BITS;

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  meta_t            meta_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '0;
    else if (alc_we) vld_q[alc_idx] <= 1'b1;
  end

  // allocation is written last so it wins over a snoop to the same entry
  always_ff @(posedge clk) begin
    if (upd_we) meta_q[upd_idx] <= upd_meta;
    if (alc_we) begin
      meta_q[alc_idx] <= alc_meta;
      tag_q[alc_idx]  <= alc_tag;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_valid[p] = vld_q[rd_idx[p]];
    assign rd_hit[p]   = vld_q[rd_idx[p]] && (tag_q[rd_idx[p]] == rd_tag[p]);
    assign rd_meta[p]  = meta_q[rd_idx[p]];
  end
endmodule

// File: rtl/lst_learn.sv
module lst_learn import lst_pkg::*; (
  input  meta_t cur,
  input  addr_t seen,
  output meta_t nxt,
  output logic  guess_ok,
  output logic  delta_fits
);
  addr_t delta;

  always_comb begin
    delta      = seen - cur.last;
    delta_fits = stride_fits(delta);
    guess_ok   = (seen == next_guess(cur));
    nxt        = cur;
    nxt.last   = seen;
    if (guess_ok) begin
      nxt.streak = bump(cur.streak);
    end else begin
      nxt.streak = '0;
      nxt.stride = delta_fits ? delta[STRIDE_W-1:0] : '0;
    end
    // R7
    fit_when_ok_chk: assert (!guess_ok || delta_fits);
  end
endmodule

// File: rtl/load_stride_tracker.sv
module load_stride_tracker import lst_pkg::*; #(
  parameter int unsigned SET_BITS = 4,
  parameter int unsigned WAYS     = 2,
  parameter int unsigned PC_LSB   = 2,
  parameter int unsigned LFSR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alc_vld,
  input  logic [PC_W-1:0]   alc_pc,
  input  logic [ADDR_W-1:0] alc_addr,
  input  logic              snp_vld,
  input  logic [PC_W-1:0]   snp_pc,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_hit,
  output logic              lk_elig,
  output logic [ADDR_W-1:0] lk_pred
);
  localparam int unsigned TAG_W = PC_W - SET_BITS - PC_LSB;
  localparam int unsigned NRD   = 3;
  localparam int unsigned P_LK  = 0;
  localparam int unsigned P_SNP = 1;
  localparam int unsigned P_ALC = 2;
  localparam int unsigned SEL_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  function automatic logic [SET_BITS-1:0] set_of(logic [PC_W-1:0] pc);
    return pc[PC_LSB +: SET_BITS];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [PC_W-1:0] pc);
    return pc[PC_W-1 -: TAG_W];
  endfunction

  // read ports: 0 lookup, 1 snoop, 2 allocate
  logic [NRD-1:0][SET_BITS-1:0] rd_idx;
  logic [NRD-1:0][TAG_W-1:0]    rd_tag;
  assign rd_idx = {set_of(alc_pc), set_of(snp_pc), set_of(lk_pc)};
  assign rd_tag = {tag_of(alc_pc), tag_of(snp_pc), tag_of(lk_pc)};

  logic [WAYS-1:0][NRD-1:0] way_hit, way_vld;
  meta_t [WAYS-1:0][NRD-1:0] way_meta;
  logic [NRD-1:0][WAYS-1:0] port_hit;
  meta_t [NRD-1:0]          port_meta;

  always_comb begin
    port_hit  = '0;
    port_meta = '0;
    for (int p = 0; p < NRD; p++) begin
      for (int w = 0; w < WAYS; w++) begin
        port_hit[p][w] = way_hit[w][p];
        if (way_hit[w][p]) port_meta[p] = port_meta[p] | way_meta[w][p];
      end
    end
  end

  // victim choice: first invalid way, else pseudo-random
  logic [LFSR_W-1:0] lfsr_q;
  logic [SEL_W-1:0]  rnd_way;
  logic [WAYS-1:0]   victim_oh;
  logic              free_found;
  assign rnd_way = lfsr_q[SEL_W-1:0];

  lst_lfsr #(.W(LFSR_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .state(lfsr_q));

  always_comb begin
    victim_oh  = '0;
    free_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!free_found && !way_vld[w][P_ALC]) begin
        victim_oh[w] = 1'b1;
        free_found   = 1'b1;
      end
    end
    if (!free_found) begin
      for (int w = 0; w < WAYS; w++) victim_oh[w] = (w == (int'(rnd_way) % WAYS));
    end
  end

  // allocate-port update
  logic  alc_hits;
  meta_t alc_meta_new;
  assign alc_hits = |port_hit[P_ALC];

  always_comb begin
    if (alc_hits) begin
      alc_meta_new        = port_meta[P_ALC];
      alc_meta_new.misses = bump(port_meta[P_ALC].misses);
    end else begin
      alc_meta_new = '{last: alc_addr, stride: '0, misses: '0, streak: '0};
    end
  end

  // snoop-port update
  meta_t snp_meta_new;
  logic  snp_guess_ok, snp_delta_fits;

  lst_learn u_learn (
    .cur(port_meta[P_SNP]), .seen(snp_addr), .nxt(snp_meta_new),
    .guess_ok(snp_guess_ok), .delta_fits(snp_delta_fits)
  );

  logic [WAYS-1:0] alc_we_w, upd_we_w;
  assign alc_we_w = alc_vld ? (alc_hits ? port_hit[P_ALC] : victim_oh) : '0;
  assign upd_we_w = snp_vld ? port_hit[P_SNP] : '0;

  logic [SET_BITS-1:0] snp_idx, alc_idx;
  logic [TAG_W-1:0]    alc_tag;
  assign snp_idx = set_of(snp_pc);
  assign alc_idx = set_of(alc_pc);
  assign alc_tag = tag_of(alc_pc);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    lst_way #(.SET_BITS(SET_BITS), .TAG_W(TAG_W), .NRD(NRD)) u_way (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(rd_idx), .rd_tag(rd_tag),
      .rd_hit(way_hit[w]), .rd_valid(way_vld[w]), .rd_meta(way_meta[w]),
      .upd_we(upd_we_w[w]), .upd_idx(snp_idx), .upd_meta(snp_meta_new),
      .alc_we(alc_we_w[w]), .alc_idx(alc_idx), .alc_tag(alc_tag), .alc_meta(alc_meta_new)
    );
  end

  assign lk_hit  = |port_hit[P_LK];
  assign lk_pred = next_guess(port_meta[P_LK]);
  assign lk_elig = lk_hit && (port_meta[P_LK].misses == CNT_TOP)
                          && (port_meta[P_LK].streak == CNT_TOP);

  // R2
  lk_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(port_hit[P_LK]));
  // R2
  snp_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(port_hit[P_SNP]));
  // R4
  alc_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n) alc_vld |-> $onehot(alc_we_w));
  // R10
  lk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lk_pc) && $past(alc_we_w == '0 && upd_we_w == '0)) |-> ($stable(lk_pred) && $stable(lk_hit)));
endmodule

// File: tb/test_load_stride_tracker.sv
module test_load_stride_tracker;
  localparam int HALF = 2500; // 200 MHz clock, delays in ps

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #HALF clk = ~clk;

  logic        alc_vld = 1'b0, snp_vld = 1'b0;
  logic [31:0] alc_pc = '0, alc_addr = '0, snp_pc = '0, snp_addr = '0, lk_pc = '0;
  logic        lk_hit, lk_elig, dm_hit, dm_elig;
  logic [31:0] lk_pred, dm_pred;

  load_stride_tracker i_load_stride_tracker (
    .clk(clk), .rst_n(rst_n),
    .alc_vld(alc_vld), .alc_pc(alc_pc), .alc_addr(alc_addr),
    .snp_vld(snp_vld), .snp_pc(snp_pc), .snp_addr(snp_addr),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_elig(lk_elig), .lk_pred(lk_pred)
  );

  load_stride_tracker #(.WAYS(1)) i_load_stride_tracker_dm (
    .clk(clk), .rst_n(rst_n),
    .alc_vld(alc_vld), .alc_pc(alc_pc), .alc_addr(alc_addr),
    .snp_vld(snp_vld), .snp_pc(snp_pc), .snp_addr(snp_addr),
    .lk_pc(lk_pc), .lk_hit(dm_hit), .lk_elig(dm_elig), .lk_pred(dm_pred)
  );

  typedef struct {
    bit          dm;
    logic        hit;
    logic        elig;
    logic [31:0] pred;
    bit          use_pred;
    string       req;
  } exp_t;

  exp_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %s expected %s", req, act, exp);
    end
  endtask

  // monitor: compares queued expectations away from the clock edge
  initial forever begin
    exp_t e;
    logic h, el;
    logic [31:0] pr;
    @(negedge clk);
    #(HALF/2);
    while (sb.size() > 0) begin
      e  = sb.pop_front();
      h  = e.dm ? dm_hit  : lk_hit;
      el = e.dm ? dm_elig : lk_elig;
      pr = e.dm ? dm_pred : lk_pred;
      check((h == e.hit) && (el == e.elig) && (!e.use_pred || pr == e.pred), e.req,
            $sformatf("hit=%0b elig=%0b pred=%h", h, el, pr),
            $sformatf("hit=%0b elig=%0b pred=%h", e.hit, e.elig, e.pred));
    end
  end

  task automatic cyc(input logic av, input logic [31:0] apc, input logic [31:0] aad,
                     input logic sv, input logic [31:0] spc, input logic [31:0] sad);
    @(negedge clk);
    alc_vld = av; alc_pc = apc; alc_addr = aad;
    snp_vld = sv; snp_pc = spc; snp_addr = sad;
  endtask

  task automatic alloc(input logic [31:0] pc, input logic [31:0] ad);
    cyc(1'b1, pc, ad, 1'b0, '0, '0);
  endtask

  task automatic snoop(input logic [31:0] pc, input logic [31:0] ad);
    cyc(1'b0, '0, '0, 1'b1, pc, ad);
  endtask

  task automatic want(input bit dm, input logic [31:0] pc, input logic h, input logic el,
                      input logic [31:0] pr, input bit up, input string req);
    exp_t e;
    lk_pc = pc;
    e = '{dm, h, el, pr, up, req};
    sb.push_back(e);
  endtask

  task automatic look(input bit dm, input logic [31:0] pc, input logic h, input logic el,
                      input logic [31:0] pr, input bit up, input string req);
    cyc(1'b0, '0, '0, 1'b0, '0, '0);
    want(dm, pc, h, el, pr, up, req);
  endtask

  localparam logic [31:0] PC_P = 32'h0000_0108; // set 2
  localparam logic [31:0] PC_A = 32'h0000_1004; // set 1
  localparam logic [31:0] PC_B = 32'h0000_2004; // set 1
  localparam logic [31:0] PC_C = 32'h0000_3004; // set 1

  initial begin
    #(200000 * 2 * HALF);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic ha, hb, hc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    look(0, PC_P, 1'b0, 1'b0, '0, 0, "R1 empty after reset");
    look(1, PC_P, 1'b0, 1'b0, '0, 0, "R1 empty after reset (direct-mapped)");

    snoop(PC_P, 32'h500);
    look(0, PC_P, 1'b0, 1'b0, '0, 0, "R3 snoop does not allocate");

    alloc(PC_P, 32'h1000);
    look(0, PC_P, 1'b1, 1'b0, 32'h1000, 1, "R3 fresh entry stride 0");

    snoop(PC_P, 32'h1010);
    look(0, PC_P, 1'b1, 1'b0, 32'h1020, 1, "R6 wrong guess loads delta");

    snoop(PC_P, 32'h1020);
    snoop(PC_P, 32'h1030);
    snoop(PC_P, 32'h1040);
    look(0, PC_P, 1'b1, 1'b0, 32'h1050, 1, "R9 streak full, misses short");

    alloc(PC_P, 32'hDEAD_0000);
    alloc(PC_P, 32'hDEAD_0000);
    look(0, PC_P, 1'b1, 1'b0, 32'h1050, 1, "R8 repeat miss keeps address state");

    alloc(PC_P, 32'hDEAD_0000);
    look(0, PC_P, 1'b1, 1'b1, 32'h1050, 1, "R9 both counters full");

    alloc(PC_P, 32'hDEAD_0000);
    snoop(PC_P, 32'h1050);
    look(0, PC_P, 1'b1, 1'b1, 32'h1060, 1, "R6 R8 counters saturate");

    snoop(PC_P, 32'h1100);
    want(0, PC_P, 1'b1, 1'b1, 32'h1060, 1, "R10 same-cycle lookup sees old state");
    look(0, PC_P, 1'b1, 1'b0, 32'h11B0, 1, "R6 misprediction clears streak");

    snoop(PC_P, 32'h1300);
    look(0, PC_P, 1'b1, 1'b0, 32'h1300, 1, "R7 +512 does not fit");

    snoop(PC_P, 32'h12F0);
    look(0, PC_P, 1'b1, 1'b0, 32'h12E0, 1, "R5 negative stride");

    snoop(PC_P, 32'h13EF);
    look(0, PC_P, 1'b1, 1'b0, 32'h14EE, 1, "R7 +255 fits");

    snoop(PC_P, 32'h14EF);
    look(0, PC_P, 1'b1, 1'b0, 32'h14EF, 1, "R7 +256 does not fit");

    snoop(PC_P, 32'h13EF);
    look(0, PC_P, 1'b1, 1'b0, 32'h12EF, 1, "R7 -256 fits");

    cyc(1'b1, PC_P, 32'h9999, 1'b1, PC_P, 32'h12EF);
    look(0, PC_P, 1'b1, 1'b0, 32'h12EF, 1, "R11 allocate wins same-entry collision");

    alloc(PC_A, 32'h100);
    alloc(PC_B, 32'h200);
    look(0, PC_A, 1'b1, 1'b0, 32'h100, 1, "R4 first way filled");
    look(0, PC_B, 1'b1, 1'b0, 32'h200, 1, "R4 second way filled");
    look(1, PC_A, 1'b0, 1'b0, '0, 0, "R12 direct-mapped displaced");
    look(1, PC_B, 1'b1, 1'b0, 32'h200, 1, "R12 direct-mapped keeps newest");

    alloc(PC_C, 32'h300);
    look(0, PC_C, 1'b1, 1'b0, 32'h300, 1, "R4 full set replacement");

    cyc(1'b0, '0, '0, 1'b0, '0, '0);
    lk_pc = PC_A; #(HALF/5); ha = lk_hit;
    lk_pc = PC_B; #(HALF/5); hb = lk_hit;
    lk_pc = PC_C; #(HALF/5); hc = lk_hit;
    check((ha ^ hb) && hc, "R4 exactly one old way evicted",
          $sformatf("A=%0b B=%0b C=%0b", ha, hb, hc), "one of A/B, C=1");

    look(0, PC_P, 1'b1, 1'b0, 32'h12EF, 1, "R2 other set untouched");

    cyc(1'b0, '0, '0, 1'b0, '0, '0);
    @(negedge clk);
    #(HALF);
    finish_run();
  end
endmodule